// File: doc/BRIEF.md
# Processor Idle-State Entry/Exit Sequencer

This block sits on the platform side of a processor and walks it through three idle levels and back: clock-stop request, light sleep and deep sleep. When software or power management raises a sleep request, the block asserts the clock-stop request and waits for the processor to report that its stop-grant bus cycle has finished. It then freezes the processor inputs, drives the sleep control, then the deep-sleep control, and finally gates the bus clock. A wake request reverses the walk. The bus clock is turned back on, the block waits for it to settle, and then releases deep sleep. It allows the processor PLL time to lock before releasing sleep, and it holds the clock-stop request and the input freeze for a guard time after that.

Every gap between two control edges has a minimum length. While the bus clock runs, gaps are counted in bus-clock edges. The block itself runs on an always-on reference clock, which keeps running while the bus clock is stopped. The clock-settle wait and the PLL-lock wait are counted in reference cycles. A wake request that arrives before deep sleep is reached cancels the entry. Only the controls already driven are undone, in reverse order, and the same minimum gaps still apply.

Top module: `lps_seq`

## Requirements
- R1: After reset all three controls are released (clkStopReqN=1, sleepCtlN=1, deepSleepCtlN=1), busClkEn=1 and inputFreeze=0.
- R2: A sleep request with wake low drives clkStopReqN low. sleepCtlN falls only after stopGrantDone, at least GRANT_HOLD (100) and at most GRANT_HOLD+3 bus-clock edges after stopGrantDone is raised.
- R3: inputFreeze rises at least FREEZE_LEAD (10) bus-clock edges before sleepCtlN falls, and stays high for as long as sleepCtlN is low.
- R4: With no wake pending, deepSleepCtlN falls between SLP_TO_DEEP (10) and SLP_TO_DEEP+3 bus-clock edges after sleepCtlN falls.
- R5: busClkEn is low only while deepSleepCtlN is low. It is high for at least STABLE_CYC (16) reference cycles before deepSleepCtlN rises.
- R6: sleepCtlN rises between LOCK_CYC and LOCK_CYC+2 reference cycles after deepSleepCtlN rises. LOCK_CYC = REF_MHZ*LOCK_US = 1500.
- R7: clkStopReqN and inputFreeze are released together, between EXIT_HOLD (10) and EXIT_HOLD+3 bus-clock edges after sleepCtlN rises.
- R8: sleepCtlN is low only while clkStopReqN is low, and deepSleepCtlN is low only while sleepCtlN is low.
- R9: A wake during the stop-grant wait or the pre-sleep freeze releases clkStopReqN and inputFreeze within two reference cycles. sleepCtlN is never driven low in that case.
- R10: A wake while in light sleep (before deep sleep) leaves deepSleepCtlN high and exits through the R7 guard time.
- R11: Deep sleep, with busClkEn low, persists until wake is raised. In the running state a wake request overrides a sleep request, so no entry starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock; all state is clocked here |
| rstN | input | 1 | Active-low asynchronous reset |
| busClk | input | 1 | Processor bus clock, sampled to count its rising edges |
| sleepReq | input | 1 | Level request to enter the idle states |
| wakeReq | input | 1 | Level request to return to running; wins over sleepReq |
| stopGrantDone | input | 1 | Processor has completed its stop-grant bus cycle |
| clkStopReqN | output | 1 | Active-low clock-stop request to the processor |
| sleepCtlN | output | 1 | Active-low sleep control |
| deepSleepCtlN | output | 1 | Active-low deep-sleep control |
| busClkEn | output | 1 | Enable for the bus clock generator |
| inputFreeze | output | 1 | Tells surrounding logic to hold processor inputs constant |

## Verification
Each state change takes effect at the reference edge that samples its cause, so an abort caused by wake shows on the outputs one edge after wake is driven. The bench samples two edges later. Bus-clock gaps see up to three reference cycles of synchroniser and edge-detect latency, and an extra edge is counted as margin. The bench therefore counts the real bus edges it generated between two output edges and accepts a window from the minimum to the minimum plus three. The PLL-lock gap is counted in reference cycles and is checked to within two cycles. All outputs are sampled on the falling reference edge, and inputs are driven three nanoseconds after the rising edge.

// File: rtl/lps_pkg.sv
package lps_pkg;

  typedef enum logic [3:0] {
    ST_RUN,
    ST_STOP_ON,
    ST_GRANT_WAIT,
    ST_PRE_SLEEP,
    ST_SLEEP,
    ST_DEEP,
    ST_CLK_RESTART,
    ST_PLL_LOCK,
    ST_SLEEP_EXIT,
    ST_STOP_EXIT
  } lpsState_e;

  typedef enum logic [2:0] {
    LIM_GRANT,
    LIM_SLP_DEEP,
    LIM_STABLE,
    LIM_LOCK,
    LIM_EXIT
  } limSel_e;

  // strobes from control to the spacing timer
  typedef struct packed {
    logic    clear;   // restart the gap count (state is changing)
    logic    useRef;  // count reference cycles instead of bus edges
    limSel_e sel;     // which minimum gap applies
  } tmrCtl_t;

endpackage

// File: rtl/lps_timer.sv
module lps_timer
  import lps_pkg::*;
#(
  parameter int GRANT_HOLD  = 100,
  parameter int FREEZE_LEAD = 10,
  parameter int SLP_TO_DEEP = 10,
  parameter int EXIT_HOLD   = 10,
  parameter int STABLE_CYC  = 16,
  parameter int LOCK_CYC    = 1500,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    busClk,
  input  tmrCtl_t ctl,
  output logic    reached
);

  // one extra bus edge covers an edge sampled just before the state change
  localparam int EDGE_MARGIN = 1;
  localparam int PRE_GAP     = (GRANT_HOLD > FREEZE_LEAD) ? GRANT_HOLD : FREEZE_LEAD;
  localparam int LIM_G       = PRE_GAP + EDGE_MARGIN;
  localparam int LIM_S       = SLP_TO_DEEP + EDGE_MARGIN;
  localparam int LIM_E       = EXIT_HOLD + EDGE_MARGIN;
  localparam int MAX_A       = (LIM_G > LOCK_CYC) ? LIM_G : LOCK_CYC;
  localparam int MAX_B       = (STABLE_CYC > LIM_S) ? STABLE_CYC : LIM_S;
  localparam int MAX_C       = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_LIM     = (MAX_C > LIM_E) ? MAX_C : LIM_E;
  localparam int CW          = $clog2(MAX_LIM + 2);

  logic [SYNC_STAGES:0] busSync;
  logic                 busTick;
  logic [CW-1:0]        cnt;
  logic [CW-1:0]        limit;

  // bus clock is asynchronous to clk: synchronise, then find rising edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busSync <= '0;
    else       busSync <= {busSync[SYNC_STAGES-1:0], busClk};
  end

  assign busTick = busSync[SYNC_STAGES-1] & ~busSync[SYNC_STAGES];

  always_comb begin
    unique case (ctl.sel)
      LIM_GRANT:    limit = CW'(LIM_G);
      LIM_SLP_DEEP: limit = CW'(LIM_S);
      LIM_STABLE:   limit = CW'(STABLE_CYC);
      LIM_LOCK:     limit = CW'(LOCK_CYC);
      LIM_EXIT:     limit = CW'(LIM_E);
      default:      limit = CW'(MAX_LIM);
    endcase
  end

  assign reached = (cnt >= limit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                cnt <= '0;
    else if (ctl.clear)                       cnt <= '0;
    else if (!reached && (ctl.useRef || busTick)) cnt <= cnt + 1'b1;
  end

  // R2: the gap counter stops once the limit is reached and never wraps
  a_r2_count_saturates: assert property (@(posedge clk) disable iff (!rstN)
    (reached && !ctl.clear && $stable(ctl.sel)) |=> $stable(cnt));

  // R6: a reference-counted gap advances by exactly one per cycle
  a_r6_ref_steps_one: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctl.useRef) && !$past(ctl.clear) && !$past(reached))
      |-> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
  import lps_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    sleepReq,
  input  logic    wakeReq,
  input  logic    stopGrantDone,
  input  logic    reached,
  output tmrCtl_t ctl,
  output logic    clkStopReqN,
  output logic    sleepCtlN,
  output logic    deepSleepCtlN,
  output logic    busClkEn,
  output logic    inputFreeze
);

  lpsState_e state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RUN:         if (sleepReq && !wakeReq) nxt = ST_STOP_ON;
      ST_STOP_ON:     nxt = wakeReq ? ST_STOP_EXIT : ST_GRANT_WAIT;
      ST_GRANT_WAIT:  if (wakeReq) nxt = ST_STOP_EXIT;
                      else if (stopGrantDone) nxt = ST_PRE_SLEEP;
      ST_PRE_SLEEP:   if (wakeReq) nxt = ST_STOP_EXIT;
                      else if (reached) nxt = ST_SLEEP;
      ST_SLEEP:       if (wakeReq) nxt = ST_SLEEP_EXIT;
                      else if (reached) nxt = ST_DEEP;
      ST_DEEP:        if (wakeReq) nxt = ST_CLK_RESTART;
      ST_CLK_RESTART: if (reached) nxt = ST_PLL_LOCK;
      ST_PLL_LOCK:    if (reached) nxt = ST_SLEEP_EXIT;
      ST_SLEEP_EXIT:  if (reached) nxt = ST_STOP_EXIT;
      ST_STOP_EXIT:   nxt = ST_RUN;
      default:        nxt = ST_RUN;
    endcase
  end

  always_comb begin
    ctl.clear  = (nxt != state);
    ctl.useRef = (state == ST_CLK_RESTART) || (state == ST_PLL_LOCK);
    unique case (state)
      ST_SLEEP:       ctl.sel = LIM_SLP_DEEP;
      ST_CLK_RESTART: ctl.sel = LIM_STABLE;
      ST_PLL_LOCK:    ctl.sel = LIM_LOCK;
      ST_SLEEP_EXIT:  ctl.sel = LIM_EXIT;
      default:        ctl.sel = LIM_GRANT;
    endcase
  end

  // outputs are registered from the next state so each edge is glitch free
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state         <= ST_RUN;
      clkStopReqN   <= 1'b1;
      sleepCtlN     <= 1'b1;
      deepSleepCtlN <= 1'b1;
      busClkEn      <= 1'b1;
      inputFreeze   <= 1'b0;
    end else begin
      state         <= nxt;
      clkStopReqN   <= (nxt == ST_RUN) || (nxt == ST_STOP_EXIT);
      sleepCtlN     <= !(nxt inside {ST_SLEEP, ST_DEEP, ST_CLK_RESTART, ST_PLL_LOCK});
      deepSleepCtlN <= !(nxt inside {ST_DEEP, ST_CLK_RESTART});
      // gate only after deep sleep has been driven for a cycle
      busClkEn      <= !((state == ST_DEEP) && (nxt == ST_DEEP));
      inputFreeze   <= nxt inside {ST_PRE_SLEEP, ST_SLEEP, ST_DEEP,
                                   ST_CLK_RESTART, ST_PLL_LOCK, ST_SLEEP_EXIT};
    end
  end

  a_r8_sleep_inside_stop: assert property (@(posedge clk) disable iff (!rstN)
    !sleepCtlN |-> !clkStopReqN);

  a_r8_deep_inside_sleep: assert property (@(posedge clk) disable iff (!rstN)
    !deepSleepCtlN |-> !sleepCtlN);

  a_r3_freeze_covers_sleep: assert property (@(posedge clk) disable iff (!rstN)
    !sleepCtlN |-> inputFreeze);

  a_r5_gate_only_in_deep: assert property (@(posedge clk) disable iff (!rstN)
    !busClkEn |-> !deepSleepCtlN);

  a_r5_clock_on_before_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(deepSleepCtlN) |-> (busClkEn && $past(busClkEn)));

  a_r6_sleep_outlasts_deep: assert property (@(posedge clk) disable iff (!rstN)
    $rose(deepSleepCtlN) |-> !sleepCtlN);

  a_r11_wake_blocks_entry: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && wakeReq) |=> (state == ST_RUN));

endmodule

// File: rtl/lps_seq.sv
module lps_seq
  import lps_pkg::*;
#(
  parameter int GRANT_HOLD  = 100,
  parameter int FREEZE_LEAD = 10,
  parameter int SLP_TO_DEEP = 10,
  parameter int EXIT_HOLD   = 10,
  parameter int REF_MHZ     = 50,
  parameter int LOCK_US     = 30,
  parameter int STABLE_CYC  = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic busClk,
  input  logic sleepReq,
  input  logic wakeReq,
  input  logic stopGrantDone,
  output logic clkStopReqN,
  output logic sleepCtlN,
  output logic deepSleepCtlN,
  output logic busClkEn,
  output logic inputFreeze
);

  localparam int LOCK_CYC = REF_MHZ * LOCK_US;

  tmrCtl_t tmrCtl;
  logic    reached;

  lps_timer #(
    .GRANT_HOLD (GRANT_HOLD),
    .FREEZE_LEAD(FREEZE_LEAD),
    .SLP_TO_DEEP(SLP_TO_DEEP),
    .EXIT_HOLD  (EXIT_HOLD),
    .STABLE_CYC (STABLE_CYC),
    .LOCK_CYC   (LOCK_CYC),
    .SYNC_STAGES(2)
  ) u_timer (
    .clk    (clk),
    .rstN   (rstN),
    .busClk (busClk),
    .ctl    (tmrCtl),
    .reached(reached)
  );

  lps_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .sleepReq     (sleepReq),
    .wakeReq      (wakeReq),
    .stopGrantDone(stopGrantDone),
    .reached      (reached),
    .ctl          (tmrCtl),
    .clkStopReqN  (clkStopReqN),
    .sleepCtlN    (sleepCtlN),
    .deepSleepCtlN(deepSleepCtlN),
    .busClkEn     (busClkEn),
    .inputFreeze  (inputFreeze)
  );

endmodule

// File: tb/lps_seq_bench.sv
module lps_seq_bench;

  localparam int GRANT_HOLD  = 100;
  localparam int FREEZE_LEAD = 10;
  localparam int SLP_TO_DEEP = 10;
  localparam int EXIT_HOLD   = 10;
  localparam int STABLE_CYC  = 16;
  localparam int LOCK_CYC    = 50 * 30;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busClk = 1'b0;
  logic sleepReq = 1'b0;
  logic wakeReq = 1'b0;
  logic stopGrantDone = 1'b0;
  logic clkStopReqN, sleepCtlN, deepSleepCtlN, busClkEn, inputFreeze;

  int tests = 0;
  int fails = 0;
  int roundId = 0;

  always #10 clk = ~clk;

  lps_seq #(
    .GRANT_HOLD(GRANT_HOLD), .FREEZE_LEAD(FREEZE_LEAD), .SLP_TO_DEEP(SLP_TO_DEEP),
    .EXIT_HOLD(EXIT_HOLD), .REF_MHZ(50), .LOCK_US(30), .STABLE_CYC(STABLE_CYC)
  ) u_lps_seq (
    .clk(clk), .rstN(rstN), .busClk(busClk), .sleepReq(sleepReq), .wakeReq(wakeReq),
    .stopGrantDone(stopGrantDone), .clkStopReqN(clkStopReqN), .sleepCtlN(sleepCtlN),
    .deepSleepCtlN(deepSleepCtlN), .busClkEn(busClkEn), .inputFreeze(inputFreeze)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit inWin(input int v, input int lo, input int hi);
    return (v >= lo) && (v <= hi);
  endfunction

  // bus clock generator plus monitor, all on the falling reference edge
  int unsigned clkCount = 0, busEdges = 0;
  int divCnt = 0;
  int tGrant = 0, tFrz = 0, tSlpFall = 0, tSlpRise = 0, tEnRise = 0, tDpRise = 0;
  int slpFallRound = -1, dpFallRound = -1, dpRiseRound = -1;
  logic pStop = 1, pSlp = 1, pDp = 1, pEn = 1, pFrz = 0, pGrant = 0;

  always @(negedge clk) begin
    clkCount++;
    if (busClkEn) begin
      divCnt = (divCnt + 1) % 4;
      if (divCnt == 1) begin busClk = 1'b1; busEdges++; end
      if (divCnt == 3) busClk = 1'b0;
    end else begin
      busClk = 1'b0;
      divCnt = 0;
    end
    if (rstN) begin
      if (stopGrantDone && !pGrant) tGrant = busEdges;
      if (inputFreeze && !pFrz) tFrz = busEdges;
      if (busClkEn && !pEn) tEnRise = clkCount;
      if (!sleepCtlN && pSlp) begin
        slpFallRound = roundId;
        tSlpFall = busEdges;
        check(inWin(busEdges - tGrant, GRANT_HOLD, GRANT_HOLD + 3), "R2 grant-to-sleep edges",
              busEdges - tGrant, GRANT_HOLD);
        check(busEdges - tFrz >= FREEZE_LEAD, "R3 freeze lead edges", busEdges - tFrz, FREEZE_LEAD);
      end
      if (!deepSleepCtlN && pDp) begin
        dpFallRound = roundId;
        check(inWin(busEdges - tSlpFall, SLP_TO_DEEP, SLP_TO_DEEP + 3), "R4 sleep-to-deep edges",
              busEdges - tSlpFall, SLP_TO_DEEP);
      end
      if (deepSleepCtlN && !pDp) begin
        dpRiseRound = roundId;
        tDpRise = clkCount;
        check(busClkEn && (clkCount - tEnRise >= STABLE_CYC), "R5 clock on before deep release",
              clkCount - tEnRise, STABLE_CYC);
      end
      if (sleepCtlN && !pSlp) begin
        tSlpRise = busEdges;
        if (dpRiseRound == roundId)
          check(inWin(clkCount - tDpRise, LOCK_CYC, LOCK_CYC + 2), "R6 lock wait cycles",
                clkCount - tDpRise, LOCK_CYC);
      end
      if (clkStopReqN && !pStop && slpFallRound == roundId) begin
        check(inWin(busEdges - tSlpRise, EXIT_HOLD, EXIT_HOLD + 3), "R7 exit hold edges",
              busEdges - tSlpRise, EXIT_HOLD);
        check(inputFreeze == 1'b0, "R7 freeze released with stop", inputFreeze, 0);
      end
      if (!sleepCtlN && (clkStopReqN || !inputFreeze))
        check(1'b0, "R8/R3 sleep outside stop or freeze", {clkStopReqN, inputFreeze}, 1);
      if (!deepSleepCtlN && sleepCtlN) check(1'b0, "R8 deep outside sleep", sleepCtlN, 0);
      if (!busClkEn && deepSleepCtlN) check(1'b0, "R5 clock gated outside deep", deepSleepCtlN, 0);
    end
    pStop = clkStopReqN; pSlp = sleepCtlN; pDp = deepSleepCtlN;
    pEn = busClkEn; pFrz = inputFreeze; pGrant = stopGrantDone;
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #3;
    end
  endtask

  task automatic waitStop(input logic lvl);
    while (clkStopReqN !== lvl) step();
  endtask

  task automatic giveGrant();
    step(5 + ($urandom % 20));
    stopGrantDone = 1'b1;
    step();
    stopGrantDone = 1'b0;
  endtask

  task automatic finishRound();
    waitStop(1'b1);
    step(2);
    sleepReq = 1'b0;
    wakeReq = 1'b0;
    step(5);
  endtask

  task automatic runRound(input int mode);
    roundId++;
    sleepReq = 1'b1;
    waitStop(1'b0);
    if (mode == 1) begin
      step(5 + ($urandom % 25));
      wakeReq = 1'b1;
      step(2);
      check(clkStopReqN && !inputFreeze, "R9 abort in grant wait", clkStopReqN, 1);
      check(slpFallRound != roundId, "R9 no sleep after abort", slpFallRound, -1);
    end else begin
      giveGrant();
      if (mode == 2) begin
        step(5 + ($urandom % 150));
        wakeReq = 1'b1;
        step(2);
        check(clkStopReqN && !inputFreeze, "R9 abort in pre-sleep", clkStopReqN, 1);
        check(slpFallRound != roundId, "R9 no sleep after abort", slpFallRound, -1);
      end else begin
        while (sleepCtlN) step();
        if (mode == 3) begin
          step($urandom % 20);
          wakeReq = 1'b1;
          waitStop(1'b1);
          check(dpFallRound != roundId, "R10 deep never driven", dpFallRound, -1);
        end else begin
          while (deepSleepCtlN) step();
          step((mode == 4) ? 200 : 20 + ($urandom % 60));
          if (mode == 4)
            check(!deepSleepCtlN && !busClkEn && !sleepCtlN, "R11 deep holds without wake",
                  {deepSleepCtlN, busClkEn}, 0);
          wakeReq = 1'b1;
          waitStop(1'b1);
          check(dpRiseRound == roundId, "R6 full exit completed", dpRiseRound, roundId);
        end
      end
    end
    finishRound();
  endtask

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'd2024);
    step(3);
    rstN = 1'b1;
    step();
    check(clkStopReqN && sleepCtlN && deepSleepCtlN && busClkEn && !inputFreeze,
          "R1 reset levels", {clkStopReqN, sleepCtlN, deepSleepCtlN, busClkEn, inputFreeze}, 5'b11110);
    // R11: wake overrides a simultaneous sleep request while running
    sleepReq = 1'b1;
    wakeReq = 1'b1;
    step(20);
    check(clkStopReqN == 1'b1, "R11 wake beats sleep in run", clkStopReqN, 1);
    sleepReq = 1'b0;
    wakeReq = 1'b0;
    step(3);
    // directed: one of each mode, then random
    for (int m = 0; m < 5; m++) runRound(m);
    for (int r = 0; r < 20; r++) runRound($urandom % 5);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule